// File: doc/BRIEF.md
# External Radio Coexistence Arbiter

This block settles, cycle by cycle, whether a neighbouring radio (an 802.15.4 or cellular modem, for instance) or the on-chip Wi-Fi gets the air. The external radio raises a request line and then spells out its priority serially on a single priority pin, one bit per clock. It may also send its traffic direction as one more bit on that same pin. The block weighs that priority, the direction and a frequency-overlap flag against the Wi-Fi request, priority and direction. It then drives a registered grant to each side.

When the two radios sit on non-overlapping channels, both are granted together. When they overlap, the higher priority wins. A configuration bit decides one special tie: an external receive against a Wi-Fi transmit at equal priority. A grant lasts while the request stays high and the external radio keeps winning. It falls one clock after the request drops, or one clock after a stronger Wi-Fi request appears. The configuration inputs are expected to change only while no external request is in progress.

Top module: `coex_arbiter`

## Requirements
- R1: While reset is high, and on the first clock edge after it, both grant outputs are 0.
- R2: The first clock edge that sees `ext_req` high starts a transaction. The priority pin is then sampled, most significant bit first, on the following consecutive edges. `ext_grant` stays 0 until the edge that follows the last sample, and that edge is the first at which it can be 1.
- R3: With `cfg_prio_wide`=0 one priority sample is taken, and it counts as priority 3 when 1 and priority 0 when 0. With `cfg_prio_wide`=1 two samples form a 2-bit priority.
- R4: With `cfg_dir_on_prio`=1 one more sample, taken in the slot after the priority bits, gives the direction and `ext_dir` is ignored. With `cfg_dir_on_prio`=0 the direction is read live from `ext_dir`. In both cases 1 means transmit and 0 means receive.
- R5: When `ext_overlap`=0 the external radio is granted whatever the Wi-Fi is doing, and a requesting Wi-Fi is granted in the same cycle.
- R6: When `ext_overlap`=1 the external radio is granted if Wi-Fi is not requesting, or if its priority is greater than or equal to `wifi_prio`. Otherwise the grant is withheld. The one exception to this rule is set by R7.
- R7: At equal priority with the external radio receiving and Wi-Fi transmitting (`wifi_dir`=1), the external radio is granted only when `cfg_rx_tie_win`=1.
- R8: Each edge re-evaluates the grant while `ext_req` stays high. The edge that sees `ext_req` low clears `ext_grant` and ends the transaction.
- R9: A Wi-Fi request of strictly higher priority under overlap clears `ext_grant` at the next edge. The grant returns once Wi-Fi stops winning.
- R10: `wifi_grant` is registered and equals `wifi_req` unless the external radio is granted at the same edge with overlap.
- R11: If `ext_req` falls while priority bits are still being sampled, the transaction is dropped without any grant. The next request starts sampling afresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_prio_wide | input | 1 | 1: priority has PRIO_W samples; 0: one sample |
| cfg_dir_on_prio | input | 1 | 1: direction taken from the priority pin |
| cfg_rx_tie_win | input | 1 | 1: external receive wins a tie against Wi-Fi transmit |
| ext_req | input | 1 | External radio request |
| ext_prio | input | 1 | Serial priority / direction pin |
| ext_dir | input | 1 | External direction, 1 transmit, 0 receive |
| ext_overlap | input | 1 | 1 when the external channel overlaps Wi-Fi |
| wifi_req | input | 1 | Internal Wi-Fi request |
| wifi_prio | input | PRIO_W | Internal Wi-Fi priority |
| wifi_dir | input | 1 | Wi-Fi direction, 1 transmit |
| ext_grant | output | 1 | Grant to the external radio |
| wifi_grant | output | 1 | Grant to the internal Wi-Fi |

## Verification
The hardest case to reach is preemption in the middle of a grant. The external radio must first finish a full serial priority exchange and win. Only then can a stronger Wi-Fi request arrive and later leave. Directed sequences build that exchange bit by bit in each sampling mode and then move the Wi-Fi inputs on chosen cycles. Random phases reconfigure the block between transactions and flip the request rarely, so that many exchanges complete while the Wi-Fi inputs churn underneath them.

// File: rtl/coex_pkg.sv
package coex_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SAMP = 2'd1,
    ST_LIVE = 2'd2
  } coex_state_e;
endpackage

// File: rtl/coex_prio_sampler.sv
module coex_prio_sampler #(
  parameter int PRIO_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              shift_en,
  input  logic              bit_in,
  input  logic              wide,
  output logic [PRIO_W-1:0] prio_o
);
  logic [PRIO_W-1:0] val_q;

  generate
    if (PRIO_W == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst || clear)  val_q <= '0;
        else if (shift_en) val_q <= bit_in;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst || clear)  val_q <= '0;
        else if (shift_en) val_q <= {val_q[PRIO_W-2:0], bit_in};
      end
    end
  endgenerate

  // a single sample stands for the lowest or the highest level
  assign prio_o = wide ? val_q : {PRIO_W{val_q[0]}};
endmodule

// File: rtl/coex_win_logic.sv
module coex_win_logic #(
  parameter int PRIO_W = 2
) (
  input  logic [PRIO_W-1:0] ext_prio,
  input  logic              ext_tx,
  input  logic              overlap,
  input  logic              wifi_req,
  input  logic [PRIO_W-1:0] wifi_prio,
  input  logic              wifi_tx,
  input  logic              rx_tie_win,
  output logic              win
);
  always_comb begin
    if (!overlap || !wifi_req)    win = 1'b1;
    else if (ext_prio > wifi_prio) win = 1'b1;
    else if (ext_prio < wifi_prio) win = 1'b0;
    else if (!ext_tx && wifi_tx)   win = rx_tie_win;
    else                           win = 1'b1;
  end
endmodule

// File: rtl/coex_arbiter.sv
module coex_arbiter #(
  parameter int PRIO_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_prio_wide,
  input  logic              cfg_dir_on_prio,
  input  logic              cfg_rx_tie_win,
  input  logic              ext_req,
  input  logic              ext_prio,
  input  logic              ext_dir,
  input  logic              ext_overlap,
  input  logic              wifi_req,
  input  logic [PRIO_W-1:0] wifi_prio,
  input  logic              wifi_dir,
  output logic              ext_grant,
  output logic              wifi_grant
);
  import coex_pkg::*;

  localparam int CNT_W = $clog2(PRIO_W + 2);

  coex_state_e       state_q;
  logic [CNT_W-1:0]  slot_q;
  logic [CNT_W-1:0]  n_prio;
  logic [CNT_W-1:0]  n_total;
  logic              in_prio;
  logic              last_slot;
  logic              dir_q;
  logic              ext_tx;
  logic              win;
  logic              grant_d;
  logic              shift_en;
  logic [PRIO_W-1:0] ext_level;
  logic              ext_grant_q;
  logic              wifi_grant_q;

  assign n_prio    = cfg_prio_wide ? CNT_W'(PRIO_W) : CNT_W'(1);
  assign n_total   = n_prio + {{(CNT_W-1){1'b0}}, cfg_dir_on_prio};
  assign in_prio   = slot_q < n_prio;
  assign last_slot = slot_q == (n_total - CNT_W'(1));
  assign shift_en  = (state_q == ST_SAMP) && ext_req && in_prio;
  assign ext_tx    = cfg_dir_on_prio ? dir_q : ext_dir;

  coex_prio_sampler #(.PRIO_W(PRIO_W)) u_sampler (
    .clk      (clk),
    .rst      (rst),
    .clear    (state_q == ST_IDLE),
    .shift_en (shift_en),
    .bit_in   (ext_prio),
    .wide     (cfg_prio_wide),
    .prio_o   (ext_level)
  );

  coex_win_logic #(.PRIO_W(PRIO_W)) u_win (
    .ext_prio   (ext_level),
    .ext_tx     (ext_tx),
    .overlap    (ext_overlap),
    .wifi_req   (wifi_req),
    .wifi_prio  (wifi_prio),
    .wifi_tx    (wifi_dir),
    .rx_tie_win (cfg_rx_tie_win),
    .win        (win)
  );

  assign grant_d = (state_q == ST_LIVE) && ext_req && win;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      slot_q  <= '0;
      dir_q   <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          slot_q <= '0;
          if (ext_req) state_q <= ST_SAMP;
        end
        ST_SAMP: begin
          if (!ext_req) begin
            state_q <= ST_IDLE;
          end else begin
            if (!in_prio) dir_q <= ext_prio;
            slot_q <= slot_q + CNT_W'(1);
            if (last_slot) state_q <= ST_LIVE;
          end
        end
        ST_LIVE: begin
          if (!ext_req) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ext_grant_q  <= 1'b0;
      wifi_grant_q <= 1'b0;
    end else begin
      ext_grant_q  <= grant_d;
      wifi_grant_q <= wifi_req && !(grant_d && ext_overlap);
    end
  end

  assign ext_grant  = ext_grant_q;
  assign wifi_grant = wifi_grant_q;
endmodule

// File: rtl/coex_arbiter_chk.sv
module coex_arbiter_chk #(
  parameter int PRIO_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              ext_req,
  input logic              ext_overlap,
  input logic              wifi_req,
  input logic [PRIO_W-1:0] wifi_prio,
  input logic              ext_grant,
  input logic              wifi_grant
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!ext_grant && !wifi_grant));

  // R8
  req_drop_chk: assert property (@(posedge clk) disable iff (rst)
    !ext_req |=> !ext_grant);

  // R2
  grant_after_sampling_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ext_grant) |-> ($past(ext_req) && $past(ext_req, 2)));

  // R10
  exclusive_overlap_chk: assert property (@(posedge clk) disable iff (rst)
    (ext_grant && wifi_grant) |-> !$past(ext_overlap));

  // R10
  wifi_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
    wifi_grant |-> $past(wifi_req));

  // R5
  wifi_free_channel_chk: assert property (@(posedge clk) disable iff (rst)
    (wifi_req && !ext_overlap) |=> wifi_grant);
endmodule

bind coex_arbiter coex_arbiter_chk #(.PRIO_W(PRIO_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .ext_req     (ext_req),
  .ext_overlap (ext_overlap),
  .wifi_req    (wifi_req),
  .wifi_prio   (wifi_prio),
  .ext_grant   (ext_grant),
  .wifi_grant  (wifi_grant)
);

// File: tb/coex_arbiter_tb.sv
`timescale 1ns/1ps
module coex_arbiter_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_wide = 1'b1, cfg_dirpin = 1'b0, cfg_tie = 1'b0;
  logic ext_req = 0, ext_prio = 0, ext_dir = 0, ext_overlap = 0;
  logic wifi_req = 0, wifi_dir = 0;
  logic [1:0] wifi_prio = 0;
  logic ext_grant, wifi_grant;
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  coex_arbiter #(.PRIO_W(2)) u_dut (
    .clk(clk), .rst(rst), .cfg_prio_wide(cfg_wide), .cfg_dir_on_prio(cfg_dirpin),
    .cfg_rx_tie_win(cfg_tie), .ext_req(ext_req), .ext_prio(ext_prio),
    .ext_dir(ext_dir), .ext_overlap(ext_overlap), .wifi_req(wifi_req),
    .wifi_prio(wifi_prio), .wifi_dir(wifi_dir), .ext_grant(ext_grant),
    .wifi_grant(wifi_grant));

  function automatic bit win_f(logic [1:0] ep, bit etx, bit ov, bit wr,
                               logic [1:0] wp, bit wtx, bit tie);
    if (!ov || !wr) return 1'b1;
    if (ep > wp) return 1'b1;
    if (ep < wp) return 1'b0;
    if (!etx && wtx) return tie;
    return 1'b1;
  endfunction

  // requirement model, updated on the same edges as the design
  int m_st = 0, m_cnt = 0;
  logic [1:0] m_pv = 0;
  bit m_dir = 0, m_eg = 0, m_wg = 0;
  always @(posedge clk) begin
    int np, nt;
    bit g;
    g = 0;
    np = cfg_wide ? 2 : 1;
    nt = np + int'(cfg_dirpin);
    if (rst) begin
      m_st = 0; m_cnt = 0; m_pv = 0; m_dir = 0; m_eg = 0; m_wg = 0;
    end else begin
      case (m_st)
        0: if (ext_req) begin m_st = 1; m_cnt = 0; m_pv = 0; end
        1: if (!ext_req) m_st = 0;
           else begin
             if (m_cnt < np) m_pv = {m_pv[0], ext_prio};
             else m_dir = ext_prio;
             m_cnt++;
             if (m_cnt == nt) m_st = 2;
           end
        default: if (!ext_req) m_st = 0;
           else g = win_f(cfg_wide ? m_pv : {2{m_pv[0]}},
                          cfg_dirpin ? m_dir : ext_dir, ext_overlap,
                          wifi_req, wifi_prio, wifi_dir, cfg_tie);
      endcase
      m_eg = g;
      m_wg = wifi_req && !(g && ext_overlap);
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // every-cycle comparison against the model
  always @(negedge clk) if (!done) begin
    chk(ext_grant === m_eg, "R6 model ext_grant", ext_grant, m_eg);
    chk(wifi_grant === m_wg, "R10 model wifi_grant", wifi_grant, m_wg);
  end

  task automatic go_idle();
    @(negedge clk); ext_req = 0;
    @(negedge clk);
    @(negedge clk);
  endtask

  // drives a full serial exchange; returns just after the deciding edge
  task automatic start_txn(input logic [1:0] p, input logic d);
    @(negedge clk); ext_req = 1;
    @(negedge clk); ext_prio = cfg_wide ? p[1] : p[0];
    if (cfg_wide) begin @(negedge clk); ext_prio = p[0]; end
    if (cfg_dirpin) begin @(negedge clk); ext_prio = d; end
    @(negedge clk);
    chk(ext_grant == 1'b0, "R2 no grant before decision", ext_grant, 0);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(ext_grant == 0 && wifi_grant == 0, "R1 grants in reset", {ext_grant, wifi_grant}, 0);
    rst = 0;
    @(negedge clk);
    chk(ext_grant == 0 && wifi_grant == 0, "R1 grants after reset", {ext_grant, wifi_grant}, 0);

    // R5: no overlap, strong Wi-Fi, weak external
    wifi_req = 1; wifi_prio = 3; wifi_dir = 1; ext_overlap = 0; ext_dir = 1;
    start_txn(2'd0, 0);
    chk(ext_grant == 1, "R5 ext granted without overlap", ext_grant, 1);
    chk(wifi_grant == 1, "R5 wifi granted too", wifi_grant, 1);
    go_idle();

    // R6 / R10: overlap, external higher
    ext_overlap = 1; wifi_prio = 2;
    start_txn(2'd3, 0);
    chk(ext_grant == 1, "R6 higher ext wins", ext_grant, 1);
    chk(wifi_grant == 0, "R10 wifi blocked", wifi_grant, 0);
    go_idle();

    // R6: overlap, external lower
    wifi_prio = 3;
    start_txn(2'd1, 0);
    chk(ext_grant == 0, "R6 lower ext withheld", ext_grant, 0);
    chk(wifi_grant == 1, "R10 wifi granted", wifi_grant, 1);
    go_idle();

    // R3: one-sample priority
    cfg_wide = 0; wifi_prio = 3; ext_dir = 1;
    start_txn(2'd1, 0);
    chk(ext_grant == 1, "R3 single 1 counts as 3", ext_grant, 1);
    go_idle();
    wifi_prio = 1;
    start_txn(2'd0, 0);
    chk(ext_grant == 0, "R3 single 0 counts as 0", ext_grant, 0);
    go_idle();

    // R7: tie, external receive vs Wi-Fi transmit
    cfg_wide = 1; wifi_prio = 2; wifi_dir = 1; ext_dir = 0; cfg_tie = 0;
    start_txn(2'd2, 0);
    chk(ext_grant == 0, "R7 tie lost with cfg 0", ext_grant, 0);
    go_idle();
    cfg_tie = 1;
    start_txn(2'd2, 0);
    chk(ext_grant == 1, "R7 tie won with cfg 1", ext_grant, 1);
    go_idle();

    // R4: direction from the priority pin, ext_dir ignored
    cfg_tie = 0; cfg_dirpin = 1; ext_dir = 1;
    start_txn(2'd2, 0);
    chk(ext_grant == 0, "R4 pin says receive", ext_grant, 0);
    go_idle();
    ext_dir = 0;
    start_txn(2'd2, 1);
    chk(ext_grant == 1, "R4 pin says transmit", ext_grant, 1);

    // R8: hold, then drop one edge after request falls
    repeat (3) begin
      @(negedge clk);
      chk(ext_grant == 1, "R8 grant held", ext_grant, 1);
    end
    ext_req = 0;
    @(negedge clk);
    chk(ext_grant == 0, "R8 grant dropped", ext_grant, 0);
    go_idle();

    // R9: preemption and return
    cfg_dirpin = 0; wifi_req = 0; ext_dir = 1;
    start_txn(2'd1, 0);
    chk(ext_grant == 1, "R9 granted while Wi-Fi idle", ext_grant, 1);
    wifi_req = 1; wifi_prio = 2;
    @(negedge clk);
    chk(ext_grant == 0, "R9 preempted", ext_grant, 0);
    chk(wifi_grant == 1, "R9 wifi takes air", wifi_grant, 1);
    wifi_req = 0;
    @(negedge clk);
    chk(ext_grant == 1, "R9 grant back", ext_grant, 1);
    go_idle();

    // R11: request falls during sampling
    wifi_req = 0;
    @(negedge clk); ext_req = 1;
    @(negedge clk); ext_prio = 1;
    @(negedge clk); ext_req = 0;
    repeat (4) begin
      @(negedge clk);
      chk(ext_grant == 0, "R11 aborted exchange", ext_grant, 0);
    end
    start_txn(2'd3, 0);
    chk(ext_grant == 1, "R11 fresh exchange", ext_grant, 1);
    go_idle();

    // random phase
    void'($urandom(32'd1234));
    for (int c = 0; c < 60; c++) begin
      go_idle();
      cfg_wide = $urandom_range(0, 1);
      cfg_dirpin = $urandom_range(0, 1);
      cfg_tie = $urandom_range(0, 1);
      for (int k = 0; k < 50; k++) begin
        @(negedge clk);
        if ($urandom_range(0, 7) == 0) ext_req = ~ext_req;
        ext_prio = $urandom_range(0, 1);
        ext_dir = $urandom_range(0, 1);
        ext_overlap = ($urandom_range(0, 3) != 0);
        wifi_req = $urandom_range(0, 1);
        wifi_prio = 2'($urandom_range(0, 3));
        wifi_dir = $urandom_range(0, 1);
      end
    end
    go_idle();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule